// File: doc/BRIEF.md
# Descriptor-Driven Transfer Engine

This engine moves data between memory locations under the control of a small record kept in RAM. Each request pulse makes it copy that record into private working registers: mode fields, source address, destination address, counts and reload values. It then carries out one transfer and steps the source address as the mode asks. Unless told otherwise, it stores the changed fields back into the record. Software never touches the working registers. It prepares or inspects the record in RAM instead.

A record is five 32-bit words at a fixed base address. When write-back is disabled, the record can sit in read-only storage and every request replays exactly the same move. Three counting schemes are offered. A single-shot count raises a completion pulse. A cyclic count rewinds itself and the source pointer. A burst count moves several units per request. Mis-coded records are rejected with an error pulse and cause no side effects. Requests that arrive while a job runs are counted and served one after another.

Top module: `xfer_engine`

## Requirements
- R1: On each accepted request the engine reads the five record words at DESC_BASE + 0, 4, 8, 12, 16 in that order. Word 0 bits: [0] write-back disable, [1] reserved, [3:2] source mode, [5:4] unit size, [7:6] count scheme, [15:8] burst length. Word 1 is the source address and word 2 the destination address. Word 3 holds [15:0] count and [31:16] reload count. Word 4 is the reload source address. Words 0, 2 and 4 are never written.
- R2: Each unit is a bus read at the source address followed in the next cycle by a bus write of the same data to the destination address. bus_size_o carries the unit size code (00 byte, 01 16-bit, 10 32-bit), and data sits in the low bits. The destination address does not change.
- R3: After each unit, source mode 00 or 01 leaves the source address unchanged, 10 adds the step and 11 subtracts it. The step is 1, 2 or 4 for size code 00, 01 or 10.
- R4: With write-back enabled (bit 0 = 0), the engine writes word 1 with the updated source and then word 3 with {reload count, count}. Word 1 is written only when source mode is 10 or 11.
- R5: With bit 0 = 1, no record word is written, so repeated requests perform an identical move.
- R6: Count scheme 00 (single): each request moves one unit and decrements the count. done_o pulses for one cycle when the count becomes zero.
- R7: Count scheme 01 (cyclic): each request moves one unit. When the decremented count is zero, the count takes the reload count and the source address takes the reload source. done_o does not pulse.
- R8: Count scheme 10 (burst): each request moves burst-length units, where 0 means 256, and then decrements the count once. done_o pulses when the count becomes zero.
- R9: Size code 11 or count scheme 11 makes err_o pulse for one cycle. No bus access and no record write follow for that request.
- R10: A request pulse arriving while the engine is busy is held, and every held request is later served once. busy_o is high while a job runs or a request is held.
- R11: After reset, busy_o, done_o, err_o, dm_req_o and bus_req_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Transfer request, one per high cycle |
| busy_o | output | 1 | Job running or request held |
| done_o | output | 1 | Count reached zero (single or burst scheme) |
| err_o | output | 1 | Record rejected for an illegal code |
| dm_req_o | output | 1 | Record RAM access strobe |
| dm_we_o | output | 1 | Record RAM write enable |
| dm_addr_o | output | AW | Record RAM byte address |
| dm_wdata_o | output | DW | Record RAM write data |
| dm_rdata_i | input | DW | Record RAM read data, one cycle after the strobe |
| bus_req_o | output | 1 | Data bus access strobe |
| bus_we_o | output | 1 | Data bus write enable |
| bus_size_o | output | 2 | Unit size code |
| bus_addr_o | output | AW | Data bus byte address |
| bus_wdata_o | output | DW | Data bus write data |
| bus_rdata_i | input | DW | Data bus read data, one cycle after the strobe |

## Verification
On every cycle, the assertions check the following. Every bus write directly follows a bus read. The illegal size code never reaches the bus. An error pulse is followed by a silent cycle. done_o and err_o never coincide. No record write occurs while write-back is disabled. Bus activity always shows as busy. Address stepping, count reloads in the cyclic scheme, burst lengths including the 256-unit case, and the skipped source write-back all depend on memory contents, so only the bench's scenarios can show them. It compares RAM and data memory against a model after each job and counts the done, error and write-back events.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_FRD, ST_FCAP, ST_CHK, ST_MRD,
    ST_MWR, ST_UPD, ST_WBS, ST_WBC, ST_FIN
  } xfer_st_e;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'b00,
    XM_CYCLIC = 2'b01,
    XM_BURST  = 2'b10,
    XM_BAD    = 2'b11
  } xfer_md_e;

  localparam logic [1:0] SZ_BAD = 2'b11;
  localparam int unsigned REC_WORDS = 5;
  localparam int unsigned W_MODE = 0;
  localparam int unsigned W_SRC  = 1;
  localparam int unsigned W_DST  = 2;
  localparam int unsigned W_CNT  = 3;
  localparam int unsigned W_RSRC = 4;
endpackage

// File: rtl/xfer_rst_sync.sv
module xfer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/xfer_pending.sv
module xfer_pending #(
  parameter int unsigned W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_i,
  input  logic pop_i,
  output logic nz_o
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    unique case ({push_i, pop_i})
      2'b10:   if (cnt_q != '1) cnt_d = cnt_q + W'(1);
      2'b01:   cnt_d = cnt_q - W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign nz_o = |cnt_q;
endmodule

// File: rtl/xfer_step.sv
module xfer_step #(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] addr_i,
  input  logic [1:0]    sz_i,
  input  logic [1:0]    sm_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] step;

  always_comb begin
    step = AW'(1) << sz_i;
    if (!sm_i[1])     addr_o = addr_i;
    else if (sm_i[0]) addr_o = addr_i - step;
    else              addr_o = addr_i + step;
  end
endmodule

// File: rtl/xfer_engine.sv
module xfer_engine
  import xfer_pkg::*;
#(
  parameter int unsigned    AW        = 32,
  parameter int unsigned    DW        = 32,
  parameter int unsigned    PEND_W    = 3,
  parameter int unsigned    LEN_W     = 8,
  parameter logic [AW-1:0]  DESC_BASE = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic          dm_req_o,
  output logic          dm_we_o,
  output logic [AW-1:0] dm_addr_o,
  output logic [DW-1:0] dm_wdata_o,
  input  logic [DW-1:0] dm_rdata_i,
  output logic          bus_req_o,
  output logic          bus_we_o,
  output logic [1:0]    bus_size_o,
  output logic [AW-1:0] bus_addr_o,
  output logic [DW-1:0] bus_wdata_o,
  input  logic [DW-1:0] bus_rdata_i
);
  localparam int unsigned CW    = DW / 2;
  localparam int unsigned IDX_W = $clog2(REC_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_WORDS - 1);

  logic rst_ns, pend_nz, pop;
  xfer_st_e st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic wbd_q, wbd_d, fin_done_q, fin_done_d;
  logic [1:0] sm_q, sm_d, sz_q, sz_d;
  xfer_md_e md_q, md_d;
  logic [LEN_W-1:0] len_q, len_d, left_q, left_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d, rsrc_q, rsrc_d, src_nxt;
  logic [CW-1:0] cnt_q, cnt_d, rcnt_q, rcnt_d, cnt_dec;
  logic bad;

  xfer_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  assign pop = (st_q == ST_IDLE) && pend_nz;
  xfer_pending #(.W(PEND_W)) u_pend (
    .clk(clk), .rst_n(rst_ns), .push_i(req_i), .pop_i(pop), .nz_o(pend_nz)
  );

  xfer_step #(.AW(AW)) u_step (
    .addr_i(src_q), .sz_i(sz_q), .sm_i(sm_q), .addr_o(src_nxt)
  );

  assign bad     = (sz_q == SZ_BAD) || (md_q == XM_BAD);
  assign cnt_dec = cnt_q - CW'(1);

  always_comb begin
    st_d = st_q;  idx_d = idx_q;  wbd_d = wbd_q;  sm_d = sm_q;  sz_d = sz_q;
    md_d = md_q;  len_d = len_q;  left_d = left_q; src_d = src_q; dst_d = dst_q;
    rsrc_d = rsrc_q; cnt_d = cnt_q; rcnt_d = rcnt_q; fin_done_d = fin_done_q;
    dm_req_o = 1'b0; dm_we_o = 1'b0; dm_wdata_o = '0;
    dm_addr_o = DESC_BASE + AW'({idx_q, 2'b00});
    bus_req_o = 1'b0; bus_we_o = 1'b0; bus_addr_o = src_q; bus_wdata_o = '0;
    err_o = 1'b0; done_o = 1'b0;
    unique case (st_q)
      ST_IDLE: if (pend_nz) begin idx_d = '0; st_d = ST_FRD; end
      ST_FRD: begin dm_req_o = 1'b1; st_d = ST_FCAP; end
      ST_FCAP: begin
        unique case (idx_q)
          IDX_W'(W_MODE): begin
            wbd_d = dm_rdata_i[0];  sm_d = dm_rdata_i[3:2];
            sz_d  = dm_rdata_i[5:4]; md_d = xfer_md_e'(dm_rdata_i[7:6]);
            len_d = dm_rdata_i[8 +: LEN_W];
          end
          IDX_W'(W_SRC): src_d = AW'(dm_rdata_i);
          IDX_W'(W_DST): dst_d = AW'(dm_rdata_i);
          IDX_W'(W_CNT): begin cnt_d = dm_rdata_i[CW-1:0]; rcnt_d = dm_rdata_i[DW-1:CW]; end
          default:       rsrc_d = AW'(dm_rdata_i);
        endcase
        if (idx_q == IDX_LAST) st_d = ST_CHK;
        else begin idx_d = idx_q + IDX_W'(1); st_d = ST_FRD; end
      end
      ST_CHK: begin
        fin_done_d = 1'b0;
        left_d = (md_q == XM_BURST) ? len_q : LEN_W'(1);
        if (bad) begin err_o = 1'b1; st_d = ST_IDLE; end
        else st_d = ST_MRD;
      end
      ST_MRD: begin bus_req_o = 1'b1; st_d = ST_MWR; end
      ST_MWR: begin
        bus_req_o = 1'b1; bus_we_o = 1'b1; bus_addr_o = dst_q;
        bus_wdata_o = bus_rdata_i;
        src_d  = src_nxt;
        left_d = left_q - LEN_W'(1);
        st_d   = (left_q == LEN_W'(1)) ? ST_UPD : ST_MRD;
      end
      ST_UPD: begin
        cnt_d = cnt_dec;
        if (md_q == XM_CYCLIC) begin
          if (cnt_dec == '0) begin cnt_d = rcnt_q; src_d = rsrc_q; end
        end else fin_done_d = (cnt_dec == '0);
        if (wbd_q)          st_d = ST_FIN;
        else if (sm_q[1])   st_d = ST_WBS;
        else                st_d = ST_WBC;
      end
      ST_WBS: begin
        dm_req_o = 1'b1; dm_we_o = 1'b1; dm_wdata_o = DW'(src_q);
        dm_addr_o = DESC_BASE + AW'(4 * W_SRC); st_d = ST_WBC;
      end
      ST_WBC: begin
        dm_req_o = 1'b1; dm_we_o = 1'b1; dm_wdata_o = {rcnt_q, cnt_q};
        dm_addr_o = DESC_BASE + AW'(4 * W_CNT); st_d = ST_FIN;
      end
      default: begin done_o = fin_done_q; st_d = ST_IDLE; end
    endcase
  end

  assign busy_o     = (st_q != ST_IDLE) || pend_nz;
  assign bus_size_o = sz_q;

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q <= ST_IDLE; idx_q <= '0; wbd_q <= 1'b0; sm_q <= '0; sz_q <= '0;
      md_q <= XM_SINGLE; len_q <= '0; left_q <= '0; src_q <= '0; dst_q <= '0;
      rsrc_q <= '0; cnt_q <= '0; rcnt_q <= '0; fin_done_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; wbd_q <= wbd_d; sm_q <= sm_d; sz_q <= sz_d;
      md_q <= md_d; len_q <= len_d; left_q <= left_d; src_q <= src_d;
      dst_q <= dst_d; rsrc_q <= rsrc_d; cnt_q <= cnt_d; rcnt_q <= rcnt_d;
      fin_done_q <= fin_done_d;
    end
  end
endmodule

// File: rtl/xfer_engine_chk.sv
module xfer_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dm_req_o,
  input logic       dm_we_o,
  input logic       bus_req_o,
  input logic       bus_we_o,
  input logic [1:0] bus_size_o,
  input logic       err_o,
  input logic       done_o,
  input logic       busy_o,
  input logic       wbd_q
);
  p_write_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_we_o) |-> $past(bus_req_o && !bus_we_o));

  p_no_record_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wbd_q |-> !(dm_req_o && dm_we_o));

  p_done_err_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  p_legal_size_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (bus_size_o != 2'b11));

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> (!bus_req_o && !dm_req_o));

  p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req_o || bus_req_o) |-> busy_o);
endmodule

bind xfer_engine xfer_engine_chk u_chk (.*);

// File: tb/tb_xfer_engine.sv
module tb_xfer_engine;
  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0;
  logic busy, done, err, dm_req, dm_we, bus_req, bus_we;
  logic [31:0] dm_addr, dm_wdata, dm_rdata, bus_addr, bus_wdata, bus_rdata;
  logic [1:0] bus_size;

  always #2.5 clk = ~clk;

  xfer_engine dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .busy_o(busy), .done_o(done), .err_o(err),
    .dm_req_o(dm_req), .dm_we_o(dm_we), .dm_addr_o(dm_addr), .dm_wdata_o(dm_wdata),
    .dm_rdata_i(dm_rdata), .bus_req_o(bus_req), .bus_we_o(bus_we),
    .bus_size_o(bus_size), .bus_addr_o(bus_addr), .bus_wdata_o(bus_wdata),
    .bus_rdata_i(bus_rdata)
  );

  logic [7:0]  dmem [256];
  logic [31:0] dram [8];
  logic [7:0]  edm  [256];
  logic [31:0] edr  [8];
  logic sync = 1'b0;
  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, err_cnt = 0, wb_tot = 0, exp_done = 0, exp_err = 0, exp_wb = 0;
  int wb_cnt [8];

  function automatic logic [31:0] rd_dm(input logic [7:0] a, input logic [1:0] sz);
    logic [31:0] v = '0;
    for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = dmem[8'(a + 8'(k))];
    return v;
  endfunction

  always @(posedge clk) begin
    if (sync) begin
      for (int i = 0; i < 256; i++) dmem[i] <= edm[i];
      for (int i = 0; i < 8; i++) dram[i] <= edr[i];
    end else begin
      if (dm_req && !dm_we) dm_rdata <= dram[dm_addr[4:2]];
      if (dm_req && dm_we)  dram[dm_addr[4:2]] <= dm_wdata;
      if (bus_req && !bus_we) bus_rdata <= rd_dm(bus_addr[7:0], bus_size);
      if (bus_req && bus_we)
        for (int k = 0; k < (1 << bus_size); k++) dmem[8'(bus_addr[7:0] + 8'(k))] <= bus_wdata[8*k +: 8];
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (done) done_cnt++;
    if (err)  err_cnt++;
    if (dm_req && dm_we) begin wb_cnt[dm_addr[4:2]]++; wb_tot++; end
  end

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // reference model of one request, from the requirements
  task automatic model_req();
    logic [31:0] m = edr[0], src = edr[1], dst = edr[2], v, c;
    logic [1:0] sm = m[3:2], sz = m[5:4], md = m[7:6];
    logic [15:0] cnt = edr[3][15:0], rc = edr[3][31:16];
    int n;
    if (sz == 2'b11 || md == 2'b11) begin exp_err++; return; end
    n = (md == 2'b10) ? ((m[15:8] == 8'd0) ? 256 : int'(m[15:8])) : 1;
    for (int u = 0; u < n; u++) begin
      v = '0;
      for (int k = 0; k < (1 << sz); k++) v[8*k +: 8] = edm[8'(src[7:0] + 8'(k))];
      for (int k = 0; k < (1 << sz); k++) edm[8'(dst[7:0] + 8'(k))] = v[8*k +: 8];
      if (sm == 2'b10) src = src + (32'd1 << sz);
      else if (sm == 2'b11) src = src - (32'd1 << sz);
    end
    c = {16'd0, cnt - 16'd1};
    if (md == 2'b01 && c[15:0] == 16'd0) begin cnt = rc; src = edr[4]; end
    else begin cnt = c[15:0]; if (c[15:0] == 16'd0 && md != 2'b01) exp_done++; end
    if (!m[0]) begin
      if (sm[1]) begin edr[1] = src; exp_wb++; end
      edr[3] = {rc, cnt}; exp_wb++;
    end
  endtask

  task automatic set_rec(input logic [31:0] mode, src, dst, input logic [15:0] cnt, rcnt,
                         input logic [31:0] rsrc);
    edr[0] = mode; edr[1] = src; edr[2] = dst; edr[3] = {rcnt, cnt}; edr[4] = rsrc;
    @(negedge clk) sync = 1'b1;
    @(negedge clk) sync = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    int cyc = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk) req = 1'b1;
      model_req();
    end
    @(negedge clk) req = 1'b0;
    while (busy) begin
      @(negedge clk);
      cyc++;
      if (cyc > 4000) begin
        chk(1'b0, {tag, " watchdog"}, 64'(cyc), 64'd4000);
        finish_run();
      end
    end
    begin
      int bad = -1;
      for (int i = 255; i >= 0; i--) if (dmem[i] !== edm[i]) bad = i;
      chk(bad < 0, {tag, " R2 R3 data memory"}, (bad < 0) ? 64'd0 : 64'(dmem[bad]),
          (bad < 0) ? 64'd0 : 64'(edm[bad]));
      bad = -1;
      for (int i = 7; i >= 0; i--) if (dram[i] !== edr[i]) bad = i;
      chk(bad < 0, {tag, " R1 R4 record"}, (bad < 0) ? 64'd0 : 64'(dram[bad]),
          (bad < 0) ? 64'd0 : 64'(edr[bad]));
    end
    chk(done_cnt == exp_done, {tag, " R6 R8 done pulses"}, 64'(done_cnt), 64'(exp_done));
    chk(err_cnt == exp_err, {tag, " R9 error pulses"}, 64'(err_cnt), 64'(exp_err));
    chk(wb_tot == exp_wb, {tag, " R4 R5 write-back count"}, 64'(wb_tot), 64'(exp_wb));
  endtask

  initial begin
    int w1, w3;
    process::self().srandom(32'h5eed1234);
    for (int i = 0; i < 8; i++) begin wb_cnt[i] = 0; edr[i] = '0; end
    for (int i = 0; i < 256; i++) edm[i] = 8'($urandom);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!busy, "R11 busy", 64'(busy), 0);
    chk(!done && !err, "R11 done/err", 64'({done, err}), 0);
    chk(!dm_req && !bus_req, "R11 strobes", 64'({dm_req, bus_req}), 0);

    // R6 single, byte, incrementing, count 1 -> done
    set_rec(32'h0000_0008, 32'h10, 32'h80, 16'd1, 16'd0, 32'h0);
    run(1, "R6 single byte inc");
    // R3 16-bit decrementing
    set_rec(32'h0000_001C, 32'h40, 32'h90, 16'd4, 16'd0, 32'h0);
    run(1, "R3 word dec");
    // R4 fixed source: word 1 not written, word 3 written
    w1 = wb_cnt[1]; w3 = wb_cnt[3];
    set_rec(32'h0000_0024, 32'h20, 32'hA0, 16'd3, 16'd0, 32'h0);
    run(1, "R4 long fixed");
    chk(wb_cnt[1] == w1, "R4 source word skipped", 64'(wb_cnt[1] - w1), 0);
    chk(wb_cnt[3] == w3 + 1, "R4 count word written", 64'(wb_cnt[3] - w3), 1);
    // R5 write-back disabled, two requests repeat identical move
    set_rec(32'h0000_0009, 32'h30, 32'hB0, 16'd1, 16'd0, 32'h0);
    run(2, "R5 no write-back");
    chk(dmem[8'hB0] == dmem[8'h30], "R5 same source reused", 64'(dmem[8'hB0]), 64'(dmem[8'h30]));
    // R7 cyclic reload
    set_rec(32'h0000_0058, 32'h50, 32'hC0, 16'd1, 16'd3, 32'h60);
    run(1, "R7 cyclic reload");
    chk(dram[1] == 32'h60, "R7 source reloaded", 64'(dram[1]), 64'h60);
    run(1, "R7 cyclic step");
    // R8 burst of 3 longwords, and burst length 0 = 256 bytes
    set_rec(32'h0000_03A8, 32'h04, 32'hD0, 16'd2, 16'd0, 32'h0);
    run(1, "R8 burst 3");
    set_rec(32'h0000_0088, 32'h00, 32'hE0, 16'd1, 16'd0, 32'h0);
    run(1, "R8 burst 256");
    chk(dram[1] == 32'h100, "R8 256 units stepped", 64'(dram[1]), 64'h100);
    // R9 illegal size and illegal scheme
    set_rec(32'h0000_0038, 32'h10, 32'h80, 16'd2, 16'd0, 32'h0);
    run(1, "R9 bad size");
    set_rec(32'h0000_00C8, 32'h10, 32'h80, 16'd2, 16'd0, 32'h0);
    run(1, "R9 bad scheme");
    // R10 back-to-back requests both served
    set_rec(32'h0000_0018, 32'h70, 32'hF0, 16'd5, 16'd0, 32'h0);
    run(3, "R10 held requests");
    chk(dram[3][15:0] == 16'd2, "R10 three decrements", 64'(dram[3][15:0]), 2);
    chk(wb_cnt[0] == 0 && wb_cnt[2] == 0 && wb_cnt[4] == 0, "R1 words 0/2/4 never written",
        64'(wb_cnt[0] + wb_cnt[2] + wb_cnt[4]), 0);

    // constrained random records
    for (int it = 0; it < 30; it++) begin
      logic [31:0] mode;
      logic [1:0] sz = 2'($urandom_range(0, 2)), md = 2'($urandom_range(0, 2));
      if ($urandom_range(0, 7) == 0) sz = 2'b11;
      if ($urandom_range(0, 7) == 0) md = 2'b11;
      mode = {16'd0, 8'($urandom_range(0, 5)), md, sz, 2'($urandom), 1'b0,
              1'($urandom_range(0, 3) == 0)};
      set_rec(mode, 32'($urandom_range(0, 255)), 32'($urandom_range(0, 255)),
              16'($urandom_range(1, 3)), 16'($urandom_range(1, 4)),
              32'($urandom_range(0, 255)));
      run($urandom_range(1, 2), "random");
    end
    finish_run();
  end
endmodule